// File: doc/BRIEF.md
# Coprocessor Bus and Reset Control

This block lets a host processor steer two level lines that run to a secondary processor: a line that asks it to give up its memory bus, and a line that holds it in reset. The host reaches the block through a 16 KiB register window on a simple synchronous bus with a byte-wide write path, a byte-wide read path and separate read and write strobes. Every access completes in one cycle.

Each line is set by writing a byte to its own offset. The line asserts when the byte written is zero and deasserts for any non-zero byte. A read at the bus-hold offset returns a status byte that is 0x01 only while both lines are asserted. A write to the mode offset at the base of the window is accepted and has no effect. Any other access is flagged on a one-cycle `unhandled` pulse and changes no state.

Read data and the `unhandled` flag are registered, so they appear in the cycle after the strobe. The two control lines are registered too, and change in the cycle after the write that sets them.

Top module: `cop_lines_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge `bus_hold`, `cop_reset`, `rd_data` and `unhandled` all become 0.
- R2: A write to offset 0x100 sets `bus_hold` at the next edge: 1 if the written byte is 0x00, and 0 for any other value.
- R3: A write to offset 0x200 sets `cop_reset` at the next edge: 1 if the written byte is 0x00, and 0 for any other value.
- R4: A read at offset 0x100 returns, in the cycle after the strobe, 0x01 if `bus_hold` and `cop_reset` were both 1 in the strobe cycle, and 0x00 otherwise.
- R5: A write to offset 0x000 leaves `bus_hold` and `cop_reset` unchanged and does not raise `unhandled`.
- R6: A read at any offset other than 0x100, or a write at any offset other than 0x000, 0x100 and 0x200, pulses `unhandled` high in the next cycle only and leaves both control lines unchanged. Without such an access, `unhandled` is 0.
- R7: `rd_data` is 0x00 in every cycle that does not follow a read strobe at offset 0x100.
- R8: When a read and a write to offset 0x100 share one cycle, the read returns the status from before the write, and the write still takes effect.
- R9: A control line keeps its value in every cycle in which its own offset is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (14) | Byte offset within the window |
| wr_data | input | DATA_W (8) | Write byte |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rd_data | output | DATA_W (8) | Registered read byte |
| unhandled | output | 1 | One-cycle flag for an undecoded access |
| bus_hold | output | 1 | Request that the coprocessor release its bus |
| cop_reset | output | 1 | Hold the coprocessor in reset |

## Verification
A status read and a write to a control line can land in the same cycle. The status must come from the old line values while the new value still lands. The bench provokes this by raising both strobes at offset 0x100 with a byte that flips `bus_hold`. The scoreboard's model then expects the old status byte in the next cycle and the new line level in that same cycle. Mixed cycles are also driven in which a decoded write goes out alongside an undecoded read, so that a single `unhandled` pulse has to coexist with a valid line update.

// File: rtl/cop_lines_pkg.sv
package cop_lines_pkg;
  // Register offsets inside the host window
  localparam int unsigned OFF_MODE = 32'h000;
  localparam int unsigned OFF_HOLD = 32'h100;
  localparam int unsigned OFF_RST  = 32'h200;

  // Number of level lines driven toward the coprocessor
  localparam int unsigned NLINES   = 2;
  localparam int unsigned LINE_HOLD = 0;
  localparam int unsigned LINE_RST  = 1;

  // Status byte bit that reports "bus held and in reset"
  localparam int unsigned STAT_BIT = 0;
endpackage

// File: rtl/cop_addr_dec.sv
module cop_addr_dec
  import cop_lines_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [NLINES-1:0] line_wr,
  output logic              stat_rd,
  output logic              bad_acc
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(OFF_HOLD);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFF_RST);

  logic hit_mode, hit_hold, hit_rst;
  logic wr_known;

  always_comb begin
    hit_mode = (addr == A_MODE);
    hit_hold = (addr == A_HOLD);
    hit_rst  = (addr == A_RST);
    wr_known = hit_mode | hit_hold | hit_rst;

    line_wr            = '0;
    line_wr[LINE_HOLD] = wr_en & hit_hold;
    line_wr[LINE_RST]  = wr_en & hit_rst;

    stat_rd = rd_en & hit_hold;
    bad_acc = (rd_en & ~hit_hold) | (wr_en & ~wr_known);
  end
endmodule

// File: rtl/cop_line_regs.sv
module cop_line_regs
  import cop_lines_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] line_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NLINES-1:0] line_q
);
  logic byte_zero;
  assign byte_zero = (wr_data == '0);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)
        line_q[g] <= 1'b0;
      else if (line_wr[g])
        line_q[g] <= byte_zero;
    end
  end
endmodule

// File: rtl/cop_read_port.sv
module cop_read_port
  import cop_lines_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_rd,
  input  logic              bad_acc,
  input  logic [NLINES-1:0] line_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              unhandled
);
  logic [DATA_W-1:0] stat_byte;

  always_comb begin
    stat_byte           = '0;
    stat_byte[STAT_BIT] = &line_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      unhandled <= 1'b0;
    end else begin
      rd_data   <= stat_rd ? stat_byte : '0;
      unhandled <= bad_acc;
    end
  end
endmodule

// File: rtl/cop_lines_ctrl.sv
module cop_lines_ctrl
  import cop_lines_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 16384,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              unhandled,
  output logic              bus_hold,
  output logic              cop_reset
);
  logic [NLINES-1:0] line_wr;
  logic [NLINES-1:0] line_q;
  logic              stat_rd;
  logic              bad_acc;

  cop_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .line_wr (line_wr),
    .stat_rd (stat_rd),
    .bad_acc (bad_acc)
  );

  cop_line_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .line_wr (line_wr),
    .wr_data (wr_data),
    .line_q  (line_q)
  );

  cop_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .stat_rd   (stat_rd),
    .bad_acc   (bad_acc),
    .line_q    (line_q),
    .rd_data   (rd_data),
    .unhandled (unhandled)
  );

  assign bus_hold  = line_q[LINE_HOLD];
  assign cop_reset = line_q[LINE_RST];
endmodule

// File: rtl/cop_lines_ctrl_chk.sv
module cop_lines_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              unhandled,
  input logic              bus_hold,
  input logic              cop_reset
);
  logic at_mode, at_hold, at_rst, odd_acc;
  assign at_mode = (addr == ADDR_W'(32'h000));
  assign at_hold = (addr == ADDR_W'(32'h100));
  assign at_rst  = (addr == ADDR_W'(32'h200));
  assign odd_acc = (rd_en && !at_hold) || (wr_en && !(at_mode || at_hold || at_rst));

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!bus_hold && !cop_reset && rd_data == '0 && !unhandled));

  // R2
  p_hold_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && at_hold) |=> (bus_hold == ($past(wr_data) == '0)));

  // R3
  p_rst_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && at_rst) |=> (cop_reset == ($past(wr_data) == '0)));

  // R4 and R8: status reflects the lines of the strobe cycle
  p_status_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && at_hold) |=> (rd_data == DATA_W'({$past(bus_hold && cop_reset)})));

  // R5 and R9
  p_hold_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && at_hold) |=> $stable(bus_hold));
  p_rst_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && at_rst) |=> $stable(cop_reset));

  // R6
  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    odd_acc |=> unhandled);
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !odd_acc |=> !unhandled);

  // R7
  p_rdata_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && at_hold) |=> (rd_data == '0));
endmodule

bind cop_lines_ctrl cop_lines_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .rd_data   (rd_data),
  .unhandled (unhandled),
  .bus_hold  (bus_hold),
  .cop_reset (cop_reset)
);

// File: tb/test_cop_lines_ctrl.sv
`timescale 1ns/1ps
module test_cop_lines_ctrl;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data;
  logic              rd_en, wr_en;
  logic [DATA_W-1:0] rd_data;
  logic              unhandled, bus_hold, cop_reset;

  always #4 clk = ~clk;   // 125 MHz

  cop_lines_ctrl i_cop_lines_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data),
    .unhandled(unhandled), .bus_hold(bus_hold), .cop_reset(cop_reset)
  );

  typedef struct {
    int              req;
    logic            hold;
    logic            crst;
    logic [DATA_W-1:0] rdat;
    logic            unh;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  logic m_hold = 1'b0;
  logic m_rst  = 1'b0;

  // Driver: applies one cycle of stimulus and pushes what must follow it
  task automatic cyc(input logic r, input logic rd, input logic wr,
                     input int a, input int wd, input int req);
    exp_t e;
    @(negedge clk);
    rst = r; rd_en = rd; wr_en = wr;
    addr = ADDR_W'(a); wr_data = DATA_W'(wd);
    e.req = req;
    if (r) begin
      m_hold = 0; m_rst = 0; e.rdat = 0; e.unh = 0;
    end else begin
      e.rdat = (rd && a == 'h100) ? DATA_W'({m_hold & m_rst}) : '0;
      e.unh  = (rd && a != 'h100) ||
               (wr && !(a == 'h000 || a == 'h100 || a == 'h200));
      if (wr && a == 'h100) m_hold = (wd[7:0] == 0);
      if (wr && a == 'h200) m_rst  = (wd[7:0] == 0);
    end
    e.hold = m_hold; e.crst = m_rst;
    q.push_back(e);
  endtask

  task automatic idle(input int req);
    cyc(0, 0, 0, 'h3FF, 'hA5, req);
  endtask

  // Monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (bus_hold !== e.hold || cop_reset !== e.crst ||
            rd_data !== e.rdat || unhandled !== e.unh) begin
          errors++;
          $display("FAIL R%0d: got hold=%b rst=%b rd=%h unh=%b exp hold=%b rst=%b rd=%h unh=%b",
                   e.req, bus_hold, cop_reset, rd_data, unhandled,
                   e.hold, e.crst, e.rdat, e.unh);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; rd_en = 0; wr_en = 0; addr = '0; wr_data = '0;
    cyc(1, 0, 0, 0, 0, 1);            // R1 reset state
    cyc(1, 0, 0, 0, 0, 1);            // R1
    cyc(0, 1, 0, 'h100, 0, 4);        // R4 status with both low
    cyc(0, 0, 1, 'h100, 'h00, 2);     // R2 zero asserts hold
    cyc(0, 1, 0, 'h100, 0, 4);        // R4 only one line high
    cyc(0, 0, 1, 'h200, 'h00, 3);     // R3 zero asserts reset
    idle(9);                          // R9 lines keep value
    cyc(0, 1, 0, 'h100, 0, 4);        // R4 both high -> 0x01
    idle(7);                          // R7 data returns to zero
    cyc(0, 0, 1, 'h000, 'h00, 5);     // R5 mode write, no effect
    cyc(0, 0, 1, 'h000, 'hFF, 5);     // R5
    cyc(0, 1, 0, 'h200, 0, 6);        // R6 read at reset offset
    cyc(0, 1, 0, 'h000, 0, 6);        // R6 read at mode offset
    cyc(0, 0, 1, 'h300, 'h00, 6);     // R6 undecoded write, no change
    cyc(0, 0, 1, 'h101, 'h00, 6);     // R6 near miss
    cyc(0, 0, 1, 'h3FFF, 'h00, 6);    // R6 top of window
    idle(6);                          // R6 flag clears
    cyc(0, 1, 1, 'h100, 'h01, 8);     // R8 read old 0x01, hold drops
    cyc(0, 1, 0, 'h100, 0, 8);        // R8 new status 0x00
    cyc(0, 1, 1, 'h100, 'h00, 8);     // R8 read old 0x00, hold rises
    cyc(0, 0, 1, 'h200, 'h80, 3);     // R3 non-zero deasserts
    cyc(0, 0, 1, 'h100, 'h02, 2);     // R2 non-zero deasserts
    cyc(0, 1, 1, 'h200, 'h00, 6);     // R6 bad read with good write
    cyc(0, 0, 1, 'h100, 'h00, 2);     // R2
    cyc(0, 1, 0, 'h100, 0, 4);        // R4
    cyc(1, 1, 1, 'h300, 0, 1);        // R1 reset beats accesses
    idle(7);                          // R7
    idle(7);
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    @(posedge clk); #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule